// File: doc/BRIEF.md
# Operand Address Generator

This unit forms the operand address for a small processor with a 16-bit word-addressable memory space of 65536 locations. It looks at the opcode field of the current instruction and picks one of three address forms. The first adds a signed 9-bit displacement to the already-incremented program counter. The second takes the same sum as the location of a pointer. The third adds a signed 6-bit displacement to a base register chosen by the instruction. All sums wrap modulo 2^16, and there is no overflow indication.

The unit never touches memory. A pointer-style access is reported as a request for a second fetch. A load-address instruction gets the computed address marked as a register result, with no memory access. The base register index leaves the unit on a combinational port so that a register file can return the value in the same cycle. Results appear one clock after an instruction is accepted, and a new instruction can be accepted on every cycle.

Top module: `eag_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `out_indirect`, `out_mem_read`, `out_mem_write` and `out_reg_write` are 0 and `out_ea` is 0x0000.
- R2: Opcode `in_instr[15:12]` = 0010 (load) or 0011 (store), accepted with `in_valid`, gives `out_ea` = `in_pc_inc` + sign-extended `in_instr[8:0]` one cycle later. It also sets `out_mem_read` (0010) or `out_mem_write` (0011), with `out_indirect` = 0.
- R3: Opcode 1010 (pointer load) or 1011 (pointer store) gives the same address as R2 with `out_indirect` = 1. It also sets `out_mem_read` (1010) or `out_mem_write` (1011) for the final operand access.
- R4: `base_idx` always equals `in_instr[8:6]` in the same cycle. Opcode 0110 (load) or 0111 (store) gives `out_ea` = `base_val` + sign-extended `in_instr[5:0]` one cycle later, with the read/write flag as in R2 and `out_indirect` = 0.
- R5: Opcode 1110 gives `out_ea` = `in_pc_inc` + sign-extended `in_instr[8:0]` with `out_reg_write` = 1. `out_mem_read`, `out_mem_write` and `out_indirect` are 0.
- R6: Any other opcode accepted with `in_valid` leaves `out_valid` and every flag at 0 in the next cycle, and `out_ea` keeps its previous value.
- R7: A cycle with `in_valid` low gives `out_valid` and all flags 0 in the next cycle, and `out_ea` unchanged.
- R8: Every address sum wraps modulo 2^16.
- R9: `out_mem_read`, `out_mem_write` and `out_reg_write` are never high together in any pair. `out_indirect` is high only together with `out_mem_read` or `out_mem_write`. `out_valid` is high exactly when one of those three flags is high.
- R10: The unit accepts one instruction per cycle with a latency of one cycle, so back-to-back instructions give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc_inc | input | 16 | Program counter already incremented |
| base_idx | output | 3 | Base register index for the register file |
| base_val | input | 16 | Contents of the selected base register |
| out_valid | output | 1 | An address was produced |
| out_ea | output | 16 | Effective address |
| out_indirect | output | 1 | The address holds a pointer, so a second fetch is needed |
| out_mem_read | output | 1 | Operand is read from memory |
| out_mem_write | output | 1 | Operand is written to memory |
| out_reg_write | output | 1 | Address itself is the register result |

## Verification
Two functions can fall on the same result: the pointer request and the store direction, which coincide for opcode 1011. The same happens when that address also wraps past 0xFFFF. The bench drives pointer stores with displacements and program counter values near both ends of the address space. It then requires `out_indirect` and `out_mem_write` together, `out_mem_read` low and the wrapped sum. Random mixes of all sixteen opcodes, with `in_valid` dropping now and then, are compared against a bench model. The same mixes also check that the address holds when no address is produced.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W  = 16;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int PCOFF_W = 9;
    localparam int BOFF_W  = 6;
    localparam int RIDX_W  = 3;
    localparam int RIDX_LO = 6;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PC   = 2'd1,
        SRC_BASE = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_REG   = 2'd3
    } acc_e;

    typedef struct packed {
        logic hit;
        src_e src;
        acc_e acc;
        logic indirect;
    } mode_t;

    typedef struct packed {
        logic  valid;
        addr_t ea;
        logic  indirect;
        logic  rd;
        logic  wr;
        logic  rw;
    } result_t;

    localparam logic [OPC_W-1:0] OPC_PCLD  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_PCST  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_PTRLD = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_PTRST = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_BLD   = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_BST   = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_ADDR  = 4'b1110;

    function automatic mode_t mode_none();
        mode_t m;
        m.hit      = 1'b0;
        m.src      = SRC_NONE;
        m.acc      = ACC_NONE;
        m.indirect = 1'b0;
        return m;
    endfunction

    function automatic mode_t mode_make(input src_e s, input acc_e a, input logic ind);
        mode_t m;
        m.hit      = 1'b1;
        m.src      = s;
        m.acc      = a;
        m.indirect = ind;
        return m;
    endfunction

    function automatic result_t result_idle(input addr_t keep);
        result_t r;
        r.valid    = 1'b0;
        r.ea       = keep;
        r.indirect = 1'b0;
        r.rd       = 1'b0;
        r.wr       = 1'b0;
        r.rw       = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    output mode_t         mode
);
    always_comb begin
        unique case (opcode)
            OPC_PCLD:  mode = mode_make(SRC_PC,   ACC_READ,  1'b0);
            OPC_PCST:  mode = mode_make(SRC_PC,   ACC_WRITE, 1'b0);
            OPC_PTRLD: mode = mode_make(SRC_PC,   ACC_READ,  1'b1);
            OPC_PTRST: mode = mode_make(SRC_PC,   ACC_WRITE, 1'b1);
            OPC_BLD:   mode = mode_make(SRC_BASE, ACC_READ,  1'b0);
            OPC_BST:   mode = mode_make(SRC_BASE, ACC_WRITE, 1'b0);
            OPC_ADDR:  mode = mode_make(SRC_PC,   ACC_REG,   1'b0);
            default:   mode = mode_none();
        endcase
    end
endmodule

// File: rtl/eag_offset.sv
module eag_offset #(
    parameter int FW = 9,
    parameter int AW = 16
) (
    input  logic [FW-1:0] field,
    output logic [AW-1:0] ext
);
    generate
        if (FW < AW) begin : g_widen
            localparam int PAD = AW - FW;
            assign ext = {{PAD{field[FW-1]}}, field};
        end else begin : g_trim
            assign ext = field[AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/eag_adder.sv
module eag_adder
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  src_e          src,
    input  logic [AW-1:0] pc_inc,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc_disp,
    input  logic [AW-1:0] base_disp,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] lhs;
    logic [AW-1:0] rhs;

    always_comb begin
        unique case (src)
            SRC_BASE: begin
                lhs = base;
                rhs = base_disp;
            end
            SRC_PC: begin
                lhs = pc_inc;
                rhs = pc_disp;
            end
            default: begin
                lhs = '0;
                rhs = '0;
            end
        endcase
        sum = lhs + rhs;
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IW  = INSTR_W,
    parameter int PW  = PCOFF_W,
    parameter int BW  = BOFF_W,
    parameter int RW  = RIDX_W,
    parameter int RLO = RIDX_LO
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [IW-1:0] in_instr,
    input  logic [AW-1:0] in_pc_inc,
    output logic [RW-1:0] base_idx,
    input  logic [AW-1:0] base_val,
    output logic          out_valid,
    output logic [AW-1:0] out_ea,
    output logic          out_indirect,
    output logic          out_mem_read,
    output logic          out_mem_write,
    output logic          out_reg_write
);
    localparam int OPC_LO = IW - OPC_W;

    mode_t         mode;
    logic [AW-1:0] pc_disp;
    logic [AW-1:0] base_disp;
    logic [AW-1:0] sum;
    result_t       nxt;
    result_t       cur;

    assign base_idx = in_instr[RLO +: RW];

    eag_decode #(.OW(OPC_W)) u_dec (
        .opcode (in_instr[OPC_LO +: OPC_W]),
        .mode   (mode)
    );

    eag_offset #(.FW(PW), .AW(AW)) u_pc_off (
        .field (in_instr[PW-1:0]),
        .ext   (pc_disp)
    );

    eag_offset #(.FW(BW), .AW(AW)) u_base_off (
        .field (in_instr[BW-1:0]),
        .ext   (base_disp)
    );

    eag_adder #(.AW(AW)) u_add (
        .src       (mode.src),
        .pc_inc    (in_pc_inc),
        .base      (base_val),
        .pc_disp   (pc_disp),
        .base_disp (base_disp),
        .sum       (sum)
    );

    always_comb begin
        nxt = result_idle(cur.ea);
        if (in_valid && mode.hit) begin
            nxt.valid    = 1'b1;
            nxt.ea       = sum;
            nxt.indirect = mode.indirect;
            nxt.rd       = (mode.acc == ACC_READ);
            nxt.wr       = (mode.acc == ACC_WRITE);
            nxt.rw       = (mode.acc == ACC_REG);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= result_idle('0);
        end else begin
            cur <= nxt;
        end
    end

    assign out_valid     = cur.valid;
    assign out_ea        = cur.ea;
    assign out_indirect  = cur.indirect;
    assign out_mem_read  = cur.rd;
    assign out_mem_write = cur.wr;
    assign out_reg_write = cur.rw;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
    parameter int AW = 16,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [IW-1:0] in_instr,
    input logic          out_valid,
    input logic [AW-1:0] out_ea,
    input logic          out_indirect,
    input logic          out_mem_read,
    input logic          out_mem_write,
    input logic          out_reg_write
);
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_mem_read, out_mem_write, out_reg_write}));

    p_indirect_needs_access_r9: assert property (@(posedge clk) disable iff (rst)
        out_indirect |-> (out_mem_read || out_mem_write));

    p_valid_matches_flags_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid == (out_mem_read || out_mem_write || out_reg_write));

    p_idle_no_result_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_holds_ea_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_ea));

    p_addr_only_no_ptr_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[IW-1 -: 4] == 4'b1110) |=> (out_reg_write && !out_indirect));

    p_ptr_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[IW-1 -: 3] == 3'b101) |=> out_indirect);
endmodule

bind eag_unit eag_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_instr      (in_instr),
    .out_valid     (out_valid),
    .out_ea        (out_ea),
    .out_indirect  (out_indirect),
    .out_mem_read  (out_mem_read),
    .out_mem_write (out_mem_write),
    .out_reg_write (out_reg_write)
);

// File: tb/tb_eag_unit.sv
`timescale 1ns/1ps
module tb_eag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic [15:0] in_pc_inc = '0;
    logic [2:0]  base_idx;
    logic [15:0] base_val;
    logic        out_valid, out_indirect, out_mem_read, out_mem_write, out_reg_write;
    logic [15:0] out_ea;

    logic [15:0] regs [8];
    int total = 0;
    int fails = 0;
    logic [15:0] model_ea = '0;

    always #2 clk = ~clk;

    assign base_val = regs[base_idx];

    eag_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_pc_inc(in_pc_inc), .base_idx(base_idx), .base_val(base_val),
        .out_valid(out_valid), .out_ea(out_ea), .out_indirect(out_indirect),
        .out_mem_read(out_mem_read), .out_mem_write(out_mem_write),
        .out_reg_write(out_reg_write)
    );

    // {valid, ea, indirect, rd, wr, rw}
    function automatic logic [20:0] expect_of(input logic v, input logic [15:0] ins,
                                              input logic [15:0] pc, input logic [15:0] keep);
        logic [15:0] pcs, bs;
        logic [3:0] op;
        pcs = pc + {{7{ins[8]}}, ins[8:0]};
        bs  = regs[ins[8:6]] + {{10{ins[5]}}, ins[5:0]};
        op  = ins[15:12];
        if (!v) return {1'b0, keep, 4'b0000};
        case (op)
            4'b0010: return {1'b1, pcs, 4'b0100};
            4'b0011: return {1'b1, pcs, 4'b0010};
            4'b1010: return {1'b1, pcs, 4'b1100};
            4'b1011: return {1'b1, pcs, 4'b1010};
            4'b0110: return {1'b1, bs,  4'b0100};
            4'b0111: return {1'b1, bs,  4'b0010};
            4'b1110: return {1'b1, pcs, 4'b0001};
            default: return {1'b0, keep, 4'b0000};
        endcase
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v) return "R7";
        case (op)
            4'b0010, 4'b0011: return "R2";
            4'b1010, 4'b1011: return "R3";
            4'b0110, 4'b0111: return "R4";
            4'b1110: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, result sampled at the following negedge (one register)
    task automatic apply(input logic v, input logic [15:0] ins, input logic [15:0] pc, input string req);
        logic [20:0] e;
        @(negedge clk);
        in_valid  = v;
        in_instr  = ins;
        in_pc_inc = pc;
        #1;
        total++;
        if (base_idx !== ins[8:6]) begin
            fails++;
            $display("FAIL R4 base_idx actual=%0d expected=%0d", base_idx, ins[8:6]);
        end
        e = expect_of(v, ins, pc, model_ea);
        model_ea = e[19:4];
        @(negedge clk);
        check(req, {out_valid, out_ea, out_indirect, out_mem_read, out_mem_write, out_reg_write}, e);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int seed;
        seed = 7321;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * i + 16'h0123;
        regs[3] = 16'hFFF0;
        regs[5] = 16'h0004;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", {out_valid, out_ea, out_indirect, out_mem_read, out_mem_write, out_reg_write}, 21'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, out_ea, out_indirect, out_mem_read, out_mem_write, out_reg_write}, 21'd0);

        // directed corners
        apply(1'b1, 16'h2005, 16'h3000, "R2");                 // +5
        apply(1'b1, 16'h31FF, 16'h3000, "R2");                 // -1 store
        apply(1'b1, 16'h2001, 16'hFFFF, "R8");                 // wrap to 0
        apply(1'b1, 16'hB100, 16'h0010, "R8");                 // ptr store -256 wraps
        apply(1'b1, 16'hB0FF, 16'hFFF0, "R3");                 // ptr store +255 wraps
        apply(1'b1, 16'hA1F0, 16'h4000, "R3");                 // ptr load
        apply(1'b1, 16'h60DF, 16'h0000, "R8");                 // base r3 + 31 wraps
        apply(1'b1, 16'h7160, 16'h0000, "R4");                 // base r5 - 32 wraps
        apply(1'b1, 16'hE1FE, 16'h0100, "R5");                 // address only
        apply(1'b1, 16'h0ABC, 16'h0100, "R6");                 // not an address op
        apply(1'b1, 16'hF025, 16'h0100, "R6");
        apply(1'b0, 16'h2005, 16'h5555, "R7");                 // dropped valid

        // back-to-back every cycle: R10
        begin
            logic [20:0] e1, e2;
            @(negedge clk);
            in_valid = 1'b1; in_instr = 16'h6A81; in_pc_inc = 16'h0000;
            #1 e1 = expect_of(1'b1, 16'h6A81, 16'h0000, model_ea);
            @(negedge clk);
            check("R10", {out_valid, out_ea, out_indirect, out_mem_read, out_mem_write, out_reg_write}, e1);
            in_instr = 16'hB07F; in_pc_inc = 16'hFF90;
            #1 e2 = expect_of(1'b1, 16'hB07F, 16'hFF90, e1[19:4]);
            @(negedge clk);
            check("R10", {out_valid, out_ea, out_indirect, out_mem_read, out_mem_write, out_reg_write}, e2);
            model_ea = e2[19:4];
        end

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic v;
            logic [15:0] ins, pc;
            v   = ($urandom % 8) != 0;
            ins = 16'($urandom);
            pc  = 16'($urandom);
            if (i % 4 == 0) pc = 16'hFFF0 | 16'($urandom % 16);
            apply(v, ins, pc, tag_of(v, ins[15:12]));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule